// File: doc/BRIEF.md
# Pseudo-DMA Pixel Shifter with Colour Map

This block sits between a processor's external memory bus and a VGA colour output. Firmware streams the bytes of a scan line by doing ordinary memory reads while a DMA enable input is high. Every such read is captured, whatever its address. Once per character cell, at a fixed pixel phase, the captured byte moves into an 8-bit shift register. It then leaves one bit per pixel clock, most significant bit first. Each bit selects one of two 3-bit colours held in a small colour register. A 1 selects the foreground colour and a 0 selects the background colour.

The block has no synchronisation with the fetch side. If firmware misses a cell, that cell is blanked to black rather than showing stale data. Blanking also follows an external retrace input. The colour register is written by a memory write made while DMA is enabled. The pixel phase and the retrace indication come from timing counters outside the block.

The fetch interface has no back-pressure. A read qualified by `dma_en` is a valid beat, and there is no ready: the beat is always taken in the cycle it appears. A later read in the same cell overwrites an earlier one. A beat that arrives after the load phase is held for the following cell.

Top module: `pdma_pixel_shifter`

## Requirements
- R1: After reset, the blanking output is 1 and the RGB outputs are 000. The colour register holds foreground white (111) and background black (000). The shift register is cleared and no byte counts as captured.
- R2: In a clock where `dma_en` and `rd_valid` are both 1, `bus_data` is captured for the next load. A read while `dma_en` is 0 captures nothing.
- R3: At the clock edge where `cell_phase` equals 6 (the seventh pixel of the cell), the shift register is loaded. Its bit 7 is shown during the next pixel (phase 7). Bits 6 down to 0 follow, one per clock, during phases 0 to 6.
- R4: If nothing was captured since the previous load, the cell that follows the load is blanked for all 8 pixels.
- R5: While blanking is active, `vid_red`, `vid_green` and `vid_blue` are all 0, never the background colour.
- R6: An unblanked pixel bit of 1 outputs the foreground colour. A bit of 0 outputs the background colour.
- R7: Colour register layout. Bit 0 is foreground red, bit 1 is foreground green and bit 2 is foreground blue. Bit 5 is background red, bit 6 is background green and bit 7 is background blue.
- R8: The colour register is written only in a clock where `dma_en` is 1, `wr_valid` is 1 and `bus_data[4]` is 0. Any other write leaves the displayed colours unchanged.
- R9: While `retrace` is 1, blanking is active in that same pixel.
- R10: A captured byte is consumed by exactly one load. A following cell with no new capture is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Qualifies memory reads and writes as video traffic |
| rd_valid | input | 1 | Memory read beat; the data is on `bus_data` |
| wr_valid | input | 1 | Memory write beat; the data is on `bus_data` |
| bus_data | input | 8 | Memory data bus |
| cell_phase | input | 3 | Pixel index within the character cell, from the external timing counters |
| retrace | input | 1 | Horizontal or vertical retrace interval |
| vid_red | output | 1 | Red output |
| vid_green | output | 1 | Green output |
| vid_blue | output | 1 | Blue output |
| blank_o | output | 1 | Blanking indication |

## Verification
A wrong shift register state shows as wrong colours within one pixel. A shift of the load phase shifts or corrupts the whole 8-pixel pattern of the next cell. A stuck capture flag appears as a cell that should be black but repeats old data, or the reverse, one cell after the missed load. A colour register that accepts a rejected write, or mixes up its fields, changes the RGB on the very next unblanked pixel. For that reason every clock is compared against a behavioural model.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef struct packed {
    logic b;
    logic g;
    logic r;
  } rgb_t;

  typedef struct packed {
    rgb_t bg;
    rgb_t fg;
  } cmap_t;

  localparam cmap_t CMAP_RESET = 6'b000_111;
  localparam rgb_t  RGB_BLACK  = 3'b000;
endpackage

// File: rtl/pdma_capture.sv
module pdma_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  input  logic              load,
  output logic [DATA_W-1:0] cap_q,
  output logic              fresh_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (take) begin
        cap_q   <= din;
        fresh_q <= 1'b1;
      end else if (load) begin
        fresh_q <= 1'b0;
      end
    end
  end

  assert_capture_sets_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> fresh_q);
  assert_load_consumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !take) |=> !fresh_q);
endmodule

// File: rtl/pdma_shifter.sv
module pdma_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              fresh,
  input  logic [DATA_W-1:0] cap,
  output logic              pix_bit,
  output logic              cell_blank
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cell_blank <= 1'b1;
    end else if (load) begin
      sh_q       <= fresh ? cap : '0;
      cell_blank <= !fresh;
    end else begin
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign pix_bit = sh_q[DATA_W-1];

  assert_missed_load_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !fresh) |=> (cell_blank && sh_q == '0));
  assert_blank_held_in_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cell_blank));
endmodule

// File: rtl/pdma_cmap.sv
module pdma_cmap
  import pdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic       guard_bit,
  input  logic [2:0] fg_in,
  input  logic [2:0] bg_in,
  output cmap_t      cmap_q
);
  logic accept;
  assign accept = wr_fire && !guard_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmap_q <= CMAP_RESET;
    end else if (accept) begin
      cmap_q.fg <= rgb_t'(fg_in);
      cmap_q.bg <= rgb_t'(bg_in);
    end
  end

  assert_cmap_rejects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire || guard_bit) |=> $stable(cmap_q));
endmodule

// File: rtl/pdma_pixel_out.sv
module pdma_pixel_out
  import pdma_pkg::*;
(
  input  logic  pix_bit,
  input  logic  cell_blank,
  input  logic  retrace,
  input  cmap_t cmap,
  output rgb_t  rgb,
  output logic  blank
);
  always_comb begin
    blank = cell_blank | retrace;
    if (blank) begin
      rgb = RGB_BLACK;
    end else if (pix_bit) begin
      rgb = cmap.fg;
    end else begin
      rgb = cmap.bg;
    end
  end
endmodule

// File: rtl/pdma_pixel_shifter.sv
module pdma_pixel_shifter
  import pdma_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LOAD_PHASE = DATA_W - 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dma_en,
  input  logic                      rd_valid,
  input  logic                      wr_valid,
  input  logic [DATA_W-1:0]         bus_data,
  input  logic [$clog2(DATA_W)-1:0] cell_phase,
  input  logic                      retrace,
  output logic                      vid_red,
  output logic                      vid_green,
  output logic                      vid_blue,
  output logic                      blank_o
);
  localparam int PH_W      = $clog2(DATA_W);
  localparam int GUARD_POS = 4;
  localparam int BG_LSB    = DATA_W - 3;

  logic              take, load, wr_fire, fresh, pix_bit, cell_blank;
  logic [DATA_W-1:0] cap;
  cmap_t             cmap;
  rgb_t              rgb;

  assign take    = dma_en && rd_valid;
  assign wr_fire = dma_en && wr_valid;
  assign load    = (cell_phase == PH_W'(LOAD_PHASE));

  pdma_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .din(bus_data), .load(load),
    .cap_q(cap), .fresh_q(fresh)
  );

  pdma_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .fresh(fresh), .cap(cap),
    .pix_bit(pix_bit), .cell_blank(cell_blank)
  );

  pdma_cmap u_cmap (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .guard_bit(bus_data[GUARD_POS]),
    .fg_in(bus_data[2:0]), .bg_in(bus_data[BG_LSB+2:BG_LSB]),
    .cmap_q(cmap)
  );

  pdma_pixel_out u_out (
    .pix_bit(pix_bit), .cell_blank(cell_blank), .retrace(retrace),
    .cmap(cmap), .rgb(rgb), .blank(blank_o)
  );

  assign vid_red   = rgb.r;
  assign vid_green = rgb.g;
  assign vid_blue  = rgb.b;

  assert_black_when_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> !(vid_red || vid_green || vid_blue));
  assert_retrace_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retrace |-> blank_o);
  assert_fg_on_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_o && pix_bit) |-> ({vid_blue, vid_green, vid_red} == cmap.fg));
endmodule

// File: tb/sim_pdma_pixel_shifter.sv
module sim_pdma_pixel_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0, rd_valid = 1'b0, wr_valid = 1'b0, retrace = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic [2:0] cell_phase = 3'd0;
  logic vid_red, vid_green, vid_blue, blank_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit q[$];
  bit [7:0] cap_m = 0;
  bit fresh_m = 0;
  bit blank_m = 1;
  bit [2:0] fg_m = 3'b111;
  bit [2:0] bg_m = 3'b000;
  int ph = 0;

  always #4 clk = ~clk;

  pdma_pixel_shifter u0 (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .rd_valid(rd_valid),
    .wr_valid(wr_valid), .bus_data(bus_data), .cell_phase(cell_phase),
    .retrace(retrace), .vid_red(vid_red), .vid_green(vid_green),
    .vid_blue(vid_blue), .blank_o(blank_o)
  );

  task automatic compare(string tag);
    bit eb;
    bit [2:0] er;
    bit [2:0] ar;
    eb = blank_m | retrace;
    er = eb ? 3'b000 : (((q.size() > 0) && q[0]) ? fg_m : bg_m);
    ar = {vid_blue, vid_green, vid_red};
    checks++;
    if (blank_o !== eb || ar !== er) begin
      errors++;
      $display("FAIL %s: blank=%0b rgb=%03b expected blank=%0b rgb=%03b (t=%0t)",
               tag, blank_o, ar, eb, er, $time);
    end
  endtask

  task automatic step(string tag);
    bit ld;
    @(posedge clk);
    ld = (ph == 6);
    if (ld) begin
      q.delete();
      for (int i = 7; i >= 0; i--) q.push_back(fresh_m ? cap_m[i] : 1'b0);
      blank_m = !fresh_m;
    end else if (q.size() > 0) begin
      void'(q.pop_front());
    end
    if (dma_en && rd_valid) begin
      cap_m = bus_data;
      fresh_m = 1;
    end else if (ld) begin
      fresh_m = 0;
    end
    if (dma_en && wr_valid && !bus_data[4]) begin
      fg_m = bus_data[2:0];
      bg_m = bus_data[7:5];
    end
    @(negedge clk);
    ph = (ph + 1) % 8;
    cell_phase = 3'(ph);
    compare(tag);
  endtask

  task automatic run_cell(bit en, bit rd, bit [7:0] rdat, bit wr, bit [7:0] wdat,
                          bit rtr, string tag);
    for (int s = 0; s < 8; s++) begin
      dma_en   = en;
      retrace  = rtr;
      rd_valid = (s == 2) && rd;
      wr_valid = (s == 4) && wr;
      bus_data = (s == 4) ? wdat : rdat;
      step(tag);
    end
    rd_valid = 0;
    wr_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    run_cell(1, 1, 8'hF0, 0, 8'h00, 0, "R1");
    run_cell(1, 1, 8'hA5, 0, 8'h00, 0, "R1");
    run_cell(1, 1, 8'h3C, 0, 8'h00, 0, "R3");
    run_cell(1, 1, 8'h81, 0, 8'h00, 0, "R6");
    run_cell(1, 0, 8'h00, 0, 8'h00, 0, "R6");
    run_cell(1, 0, 8'h00, 0, 8'h00, 0, "R4");
    run_cell(0, 1, 8'hFF, 0, 8'h00, 0, "R2");
    run_cell(1, 0, 8'h00, 0, 8'h00, 0, "R5");
    run_cell(1, 1, 8'h5A, 1, 8'h1F, 0, "R8");
    run_cell(1, 1, 8'hC3, 1, 8'b101_00_010, 0, "R8");
    run_cell(0, 0, 8'h00, 1, 8'h07, 0, "R7");
    run_cell(1, 1, 8'h96, 0, 8'h00, 0, "R8");
    run_cell(1, 1, 8'h69, 1, 8'b010_00_101, 0, "R7");
    run_cell(1, 1, 8'hFF, 0, 8'h00, 1, "R9");
    run_cell(1, 1, 8'hE7, 0, 8'h00, 0, "R9");
    run_cell(1, 0, 8'h00, 0, 8'h00, 0, "R10");
    run_cell(1, 0, 8'h00, 0, 8'h00, 0, "R10");
    run_cell(1, 1, 8'h0F, 0, 8'h00, 0, "R3");
    run_cell(1, 1, 8'hF0, 0, 8'h00, 0, "R3");
    run_cell(1, 0, 8'h00, 0, 8'h00, 0, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule